// File: doc/BRIEF.md
# Test Access Port Controller with Split Shift Ordering

This block is a boundary-test access port controller for a chip's test and debug path. It walks the standard sixteen-state TAP state machine on the rising edge of the test clock under control of the mode-select input. It keeps an 8-bit instruction and, depending on that instruction, routes shifts through either a 16-bit or an 8-bit data path. A Capture-DR state loads the selected path from a parallel input. An Update-DR state can hand the shifted-in value to a parallel output, marked by a one-cycle write strobe.

The unusual part is the bit order. Anything captured, whether the fixed identification byte 0x89 or parallel data, leaves on the serial output most significant bit first. A new instruction arrives least significant bit first, while new data arrives most significant bit first. The instruction path therefore shifts toward its top bit and reverses the received byte when it is committed. The serial output changes on the falling edge of the test clock. Outside the two shift states it is driven low, with a separate valid flag.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard sixteen-state TAP graph, advancing on the rising edge of `tck`. `rst_n` low at a rising edge forces Test-Logic-Reset and clears `upd_data` and `upd_we`.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. While in that state the instruction becomes the default 0x02, which selects the 16-bit data path with writes allowed.
- R3: In Capture-IR the instruction shift path loads 0x89, and the following Shift-IR cycles present it on `tdo` most significant bit first (1,0,0,0,1,0,0,1).
- R4: A new instruction is taken on `tdi` least significant bit first. After Update-IR, `active_instr` equals the byte whose bit 0 was the first bit shifted in.
- R5: `active_instr` changes only on the rising edge that leaves Update-IR, or while in Test-Logic-Reset. It holds its value through every shift and through the Update-IR state itself.
- R6: Instruction bit 0 selects the data path length: 1 selects 8 bits and 0 selects 16 bits. The first `tdi` bit of a data scan reappears on `tdo` after exactly that many shifts.
- R7: In Capture-DR the data path loads `cap_data` (its low 8 bits on the 8-bit path), and Shift-DR presents it on `tdo` most significant bit first.
- R8: New data enters most significant bit first. The update value is the last 8 or 16 bits shifted in, zero-extended to 16 bits on the 8-bit path.
- R9: If instruction bit 1 is 1, `upd_we` is high for exactly the one `tck` cycle after the edge leaving Update-DR, with `upd_data` carrying the update value. If bit 1 is 0, `upd_we` stays low and `upd_data` keeps its previous value.
- R10: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only in Shift-IR and Shift-DR, and `tdo` is low whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising `tck` |
| tms | input | 1 | Mode select steering the state machine |
| tdi | input | 1 | Serial data in |
| cap_data | input | 16 | Parallel value loaded in Capture-DR |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| active_instr | output | 8 | Instruction currently in force |
| upd_data | output | 16 | Parallel value written in Update-DR |
| upd_we | output | 1 | One-cycle write strobe for `upd_data` |

## Verification
The bench moves its inputs and reads every output 1 ns after each falling edge. Each sample therefore shows the state produced by the previous rising edge, plus the `tdo` bit launched on that same falling edge, which the host consumes at the next rising edge. A new instruction shows up on `active_instr` in the sample after the edge that leaves Update-IR. The sample taken while the controller sits in Update-IR must still show the old value. `upd_we` and `upd_data` are read in the sample after the edge that leaves Update-DR, and the strobe must be gone one sample later. Expected captured streams are built bit by bit from the modeled path length: the captured word first, then the `tdi` bits in order. This lets scans longer than the path also test its length.

// File: rtl/scan_port_pkg.sv
// Shared types and helpers for the test access port.
// Assumes the standard sixteen-state TAP graph; instruction field
// positions used by the decode live here so every module agrees.
package scan_port_pkg;

    typedef enum logic [3:0] {
        S_TLR, S_RTI,
        S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_t;

    // Instruction bit choosing the short data path when set.
    localparam int SEL_BIT = 0;
    // Instruction bit allowing the update write when set.
    localparam int WR_BIT  = 1;

    // Next TAP state for a given mode-select value.
    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        case (s)
            S_TLR:    n = m ? S_TLR    : S_RTI;
            S_RTI:    n = m ? S_SEL_DR : S_RTI;
            S_SEL_DR: n = m ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: n = m ? S_EX1_DR : S_SHF_DR;
            S_SHF_DR: n = m ? S_EX1_DR : S_SHF_DR;
            S_EX1_DR: n = m ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: n = m ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: n = m ? S_UPD_DR : S_SHF_DR;
            S_UPD_DR: n = m ? S_SEL_DR : S_RTI;
            S_SEL_IR: n = m ? S_TLR    : S_CAP_IR;
            S_CAP_IR: n = m ? S_EX1_IR : S_SHF_IR;
            S_SHF_IR: n = m ? S_EX1_IR : S_SHF_IR;
            S_EX1_IR: n = m ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: n = m ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: n = m ? S_UPD_IR : S_SHF_IR;
            S_UPD_IR: n = m ? S_SEL_DR : S_RTI;
            default:  n = S_TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
// TAP state register. Advances on rising tck under tms.
// Assumes rst_n is synchronous to tck and active low.
module scan_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    // Hold or advance the controller state.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            state <= S_TLR;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/scan_ir.sv
// Instruction path. The shift register moves toward its top bit: the top
// bit feeds the serial output and tdi enters at bit 0. Captured bits thus
// leave MSB first, and the first received bit ends up on top. Update-IR
// commits the bit-reversed byte, so the first received bit becomes the
// instruction's bit 0.
// Assumes the state input comes from scan_fsm in the same tck domain.
module scan_ir
    import scan_port_pkg::*;
#(
    parameter int              IR_W          = 8,
    parameter logic [IR_W-1:0] IDCODE        = 8'h89,
    parameter logic [IR_W-1:0] INSTR_DEFAULT = 8'h02
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic [IR_W-1:0] instr,
    output logic [IR_W-1:0] shift_q,
    output logic            out_bit
);

    logic [IR_W-1:0] rev;

    // Bit-reverse the shift path for the commit.
    generate
        for (genvar g = 0; g < IR_W; g++) begin : g_rev
            assign rev[g] = shift_q[IR_W-1-g];
        end
    endgenerate

    // Capture the identification byte or shift one bit per Shift-IR cycle.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (state == S_CAP_IR) begin
            shift_q <= IDCODE;
        end else if (state == S_SHF_IR) begin
            shift_q <= {shift_q[IR_W-2:0], tdi};
        end
    end

    // Commit the instruction on Update-IR, default it in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state == S_TLR) begin
            instr <= INSTR_DEFAULT;
        end else if (state == S_UPD_IR) begin
            instr <= rev;
        end
    end

    assign out_bit = shift_q[IR_W-1];

endmodule

// File: rtl/scan_dr.sv
// Data path of selectable length. A single shift register serves both
// lengths: the short path taps its serial output at bit NARROW_W-1, the
// long path at the top bit. Data moves MSB first in both directions.
// Assumes narrow and wr_ok stay stable during a data scan.
module scan_dr
    import scan_port_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  tap_state_t        state,
    input  logic              narrow,
    input  logic              wr_ok,
    input  logic [WIDE_W-1:0] cap_data,
    output logic              out_bit,
    output logic [WIDE_W-1:0] upd_data,
    output logic              upd_we
);

    localparam logic [WIDE_W-1:0] NMASK = (WIDE_W'(1) << NARROW_W) - WIDE_W'(1);

    logic [WIDE_W-1:0] sh;
    logic [WIDE_W-1:0] sel_cap;
    logic [WIDE_W-1:0] sel_upd;

    assign sel_cap = narrow ? (cap_data & NMASK) : cap_data;
    assign sel_upd = narrow ? (sh & NMASK) : sh;
    assign out_bit = narrow ? sh[NARROW_W-1] : sh[WIDE_W-1];

    // Parallel capture or one-bit shift toward the top.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (state == S_CAP_DR) begin
            sh <= sel_cap;
        end else if (state == S_SHF_DR) begin
            sh <= {sh[WIDE_W-2:0], tdi};
        end
    end

    // Write the update value and raise the strobe when writes are allowed.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            upd_data <= '0;
            upd_we   <= 1'b0;
        end else begin
            upd_we <= (state == S_UPD_DR) && wr_ok;
            if (state == S_UPD_DR && wr_ok) begin
                upd_data <= sel_upd;
            end
        end
    end

endmodule

// File: rtl/scan_tdo.sv
// Serial output stage, retimed on the falling edge of tck so the host
// can sample it safely on the next rising edge. Low and flagged invalid
// outside the shift states.
// Assumes the state and path bits are stable between rising edges.
module scan_tdo
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_t state,
    input  logic       ir_bit,
    input  logic       dr_bit,
    output logic       tdo,
    output logic       tdo_en
);

    // Pick the active path's bit, or drive low when idle.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (state == S_SHF_IR) || (state == S_SHF_DR);
            if (state == S_SHF_IR) begin
                tdo <= ir_bit;
            end else if (state == S_SHF_DR) begin
                tdo <= dr_bit;
            end else begin
                tdo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scan_port.sv
// Top of the test access port: state machine, instruction path, data
// path and serial output stage. Instruction bit SEL_BIT picks the data
// path length, and bit WR_BIT allows the update write.
// Assumes one tck domain and a synchronous active-low reset.
module scan_port
    import scan_port_pkg::*;
#(
    parameter int              IR_W          = 8,
    parameter logic [IR_W-1:0] IDCODE        = 8'h89,
    parameter logic [IR_W-1:0] INSTR_DEFAULT = 8'h02,
    parameter int              WIDE_W        = 16,
    parameter int              NARROW_W      = 8
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [WIDE_W-1:0] cap_data,
    output logic              tdo,
    output logic              tdo_en,
    output logic [IR_W-1:0]   active_instr,
    output logic [WIDE_W-1:0] upd_data,
    output logic              upd_we
);

    tap_state_t      fsm_state;
    logic [IR_W-1:0] ir_shift;
    logic            ir_bit;
    logic            dr_bit;

    scan_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (fsm_state)
    );

    scan_ir #(
        .IR_W          (IR_W),
        .IDCODE        (IDCODE),
        .INSTR_DEFAULT (INSTR_DEFAULT)
    ) u_ir (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state   (fsm_state),
        .instr   (active_instr),
        .shift_q (ir_shift),
        .out_bit (ir_bit)
    );

    scan_dr #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_dr (
        .tck      (tck),
        .rst_n    (rst_n),
        .tdi      (tdi),
        .state    (fsm_state),
        .narrow   (active_instr[SEL_BIT]),
        .wr_ok    (active_instr[WR_BIT]),
        .cap_data (cap_data),
        .out_bit  (dr_bit),
        .upd_data (upd_data),
        .upd_we   (upd_we)
    );

    scan_tdo u_tdo (
        .tck    (tck),
        .rst_n  (rst_n),
        .state  (fsm_state),
        .ir_bit (ir_bit),
        .dr_bit (dr_bit),
        .tdo    (tdo),
        .tdo_en (tdo_en)
    );

endmodule

// File: rtl/scan_port_chk.sv
// Property checker for scan_port, attached by bind. It watches ports plus
// the state and instruction shift path, and counts tms-high runs itself.
module scan_port_chk
    import scan_port_pkg::*;
#(
    parameter int              IR_W          = 8,
    parameter logic [IR_W-1:0] IDCODE        = 8'h89,
    parameter logic [IR_W-1:0] INSTR_DEFAULT = 8'h02
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input tap_state_t      state,
    input logic [IR_W-1:0] active_instr,
    input logic [IR_W-1:0] ir_shift,
    input logic            tdo,
    input logic            tdo_en,
    input logic            upd_we
);

    logic [2:0] hi_run;

    // Count consecutive tms-high edges, saturating.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            hi_run <= 3'd0;
        end else if (tms) begin
            hi_run <= (hi_run == 3'd7) ? hi_run : hi_run + 3'd1;
        end else begin
            hi_run <= 3'd0;
        end
    end

    p_tms_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_run >= 3'd5) |-> (state == S_TLR));

    p_tlr_default_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_TLR) |=> (active_instr == INSTR_DEFAULT));

    p_capture_id_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_CAP_IR) |=> (ir_shift == IDCODE));

    p_instr_hold_r5: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(active_instr) |-> ($past(state) == S_UPD_IR || $past(state) == S_TLR));

    p_we_pulse_r9: assert property (@(posedge tck) disable iff (!rst_n)
        upd_we |=> !upd_we);

    p_we_source_r9: assert property (@(posedge tck) disable iff (!rst_n)
        upd_we |-> ($past(state) == S_UPD_DR && $past(active_instr[WR_BIT])));

    p_tdo_en_r10: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (state == S_SHF_IR || state == S_SHF_DR));

    p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);

endmodule

bind scan_port scan_port_chk #(
    .IR_W          (IR_W),
    .IDCODE        (IDCODE),
    .INSTR_DEFAULT (INSTR_DEFAULT)
) u_chk (
    .tck          (tck),
    .rst_n        (rst_n),
    .tms          (tms),
    .state        (fsm_state),
    .active_instr (active_instr),
    .ir_shift     (ir_shift),
    .tdo          (tdo),
    .tdo_en       (tdo_en),
    .upd_we       (upd_we)
);

// File: tb/tb_scan_port.sv
// Self-checking bench: directed corner cases, then seeded random scans.
module tb_scan_port;

    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [15:0] cap_data = '0;
    logic        tdo, tdo_en, upd_we;
    logic [7:0]  active_instr;
    logic [15:0] upd_data;

    logic        s_tdo, s_en, s_we;
    logic [7:0]  s_ir;
    logic [15:0] s_upd;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0]  model_ir;
    logic [15:0] model_upd;

    scan_port dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .cap_data(cap_data),
        .tdo(tdo), .tdo_en(tdo_en), .active_instr(active_instr),
        .upd_data(upd_data), .upd_we(upd_we)
    );

    always #5 tck = ~tck;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge tck) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < 50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Sample outputs 1 ns after the falling edge, then drive the next inputs.
    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        s_tdo = tdo;
        s_en  = tdo_en;
        s_we  = upd_we;
        s_ir  = active_instr;
        s_upd = upd_data;
        tms = m;
        tdi = d;
    endtask

    // Expected serial stream: captured word MSB first, then tdi bits in order.
    function automatic logic [31:0] exp_stream(input int w, input logic [15:0] capv,
                                               input logic [31:0] val, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (i < w) ? capv[w-1-i] : val[n-1-(i-w)];
            r = {r[30:0], b};
        end
        return r;
    endfunction

    // Instruction scan from Run-Test/Idle, ending back in Run-Test/Idle.
    task automatic ir_scan(input logic [7:0] code, output logic [7:0] got);
        logic [7:0] old;
        old = model_ir;
        got = '0;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, code[i]);
            got = {got[6:0], s_tdo};
            if (i == 0) check("R10 tdo_en in Shift-IR", 32'(s_en), 32'd1);
        end
        step(1, 0);
        check("R10 tdo_en after Shift-IR", 32'(s_en), 32'd0);
        step(0, 0);
        check("R5 instruction held in Update-IR", 32'(s_ir), 32'(old));
        step(0, 0);
        check("R4 instruction after Update-IR", 32'(s_ir), 32'(code));
        model_ir = code;
    endtask

    // Data scan of n shifts; leaves samples of the cycle after the update edge.
    task automatic dr_scan(input int n, input logic [31:0] val, output logic [31:0] got);
        got = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, val[n-1-i]);
            got = {got[30:0], s_tdo};
        end
        step(1, 0); step(0, 0); step(0, 0);
    endtask

    // Full data scan with all checks against the model.
    task automatic dr_check(input int extra, input logic [31:0] val);
        int w;
        logic [31:0] got;
        logic [15:0] capv;
        logic [15:0] exp_upd;
        w = model_ir[0] ? 8 : 16;
        capv = model_ir[0] ? {8'h00, cap_data[7:0]} : cap_data;
        dr_scan(w + extra, val, got);
        check(extra == 0 ? "R7 captured stream" : "R6 path length stream",
              got, exp_stream(w, capv, val, w + extra));
        exp_upd = (w == 8) ? {8'h00, val[7:0]} : val[15:0];
        if (model_ir[1]) model_upd = exp_upd;
        check("R9 write strobe", 32'(s_we), 32'(model_ir[1]));
        check("R8 update value", 32'(s_upd), 32'(model_upd));
        step(0, 0);
        check("R9 strobe one cycle", 32'(s_we), 32'd0);
    endtask

    initial begin
        logic [7:0] cap;
        void'($urandom(32'd1234));
        model_ir  = 8'h02;
        model_upd = '0;

        // R1: reset state.
        repeat (4) step(1, 0);
        rst_n = 1'b1;
        step(1, 0);
        check("R1 upd_data after reset", 32'(s_upd), 32'h0);
        check("R1 upd_we after reset", 32'(s_we), 32'h0);
        check("R2 default instruction", 32'(s_ir), 32'h02);
        check("R10 tdo_en idle", 32'(s_en), 32'h0);
        step(0, 0);

        // R3/R4: short writable path.
        ir_scan(8'h03, cap);
        check("R3 captured id MSB first", 32'(cap), 32'h89);
        cap_data = 16'hA5C3;
        dr_check(0, 32'h0000_005A);
        dr_check(1, 32'h0000_01B7);

        // R9: short read-only path leaves upd_data alone.
        ir_scan(8'h01, cap);
        cap_data = 16'h3C96;
        dr_check(0, 32'h0000_00FF);

        // Long writable path, exact and overlong.
        ir_scan(8'h02, cap);
        check("R3 captured id second scan", 32'(cap), 32'h89);
        cap_data = 16'h8001;
        dr_check(0, 32'h0000_1234);
        dr_check(1, 32'h0001_F00D);

        // R2: five tms-high edges from Shift-DR return to reset.
        ir_scan(8'h41, cap);
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        step(0, 0);
        check("R2 tms reset restores default", 32'(s_ir), 32'h02);
        model_ir = 8'h02;

        // Seeded random scans.
        for (int k = 0; k < 24; k++) begin
            logic [7:0] code;
            code = 8'($urandom);
            ir_scan(code, cap);
            check("R3 captured id random", 32'(cap), 32'h89);
            cap_data = 16'($urandom);
            dr_check(int'($urandom % 3), $urandom);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule